// File: doc/BRIEF.md
# Fair Power-Aware Clock-Enable Scheduler

This block sits beside a group of N data-flow processes, each fed by input queues. Every cycle it decides which processes keep running and which are held suspended with their clock enable withdrawn. It uses each process's queue-empty flag, job-done pulse, idle flag and power estimate. Suspended processes that still have work are woken in a fair order, so no process starves. An optional cap keeps the power estimate of the newly selected runner under a limit.

Switching follows one of two policies. In cooperative mode a runner hands over when it finishes a job or goes idle. In preemptive mode a slow periodic tick forces the handover. A configuration bit bypasses the scheduler's gating and makes each clock-inhibit output follow its process's idle flag.

Top module: `fair_gate_sched`

## Requirements
- R1: While rst_n is low and in the first cycle after it, `suspended`, `clk_inhibit` and `cap_miss` are all 0 (every process runs).
- R2: Cooperative mode (`preempt_mode`=0). A switch happens when some process is stalled and a running process pulses `job_done` or has `idle`=1. A stalled process is one with its suspended bit 1 and `idle` 0. After the edge, every previously running process is suspended and exactly one stalled process runs.
- R3: Preemptive mode (`preempt_mode`=1). A switch as in R2 happens only on an edge where `slow_tick`=1 and some process is stalled. `job_done` and `idle` of runners start no switch in this mode.
- R4: Each process has an inactivity rank. The rank is cleared when the process is activated. It rises by one, saturating at N-1, on every edge where some other process is activated. The process chosen is the candidate with the highest rank. Equal ranks go to the lowest index.
- R5: If every process is suspended and any queue is non-empty, one process runs after the next edge. Stalled processes are preferred as candidates. Otherwise suspended processes with a non-empty queue are the candidates.
- R6: With no switch or wake, a running process with `idle`=1 and `q_empty`=1 is suspended at the next edge. This happens only if some other process stays running or every queue is empty.
- R7: With `cap_en`=1, only candidates whose `pwr_est` field is at most `cap_max` are chosen, if any such candidate exists. If none exists, the R4 choice among all candidates is made and `cap_miss` is 1 for the following cycle.
- R8: `clk_inhibit` is registered. When `idle_gate_cfg` was 0 at the last edge, it equals `suspended`. When it was 1, it equals the `idle` value sampled at that edge.
- R9: On an edge with no switch, wake or park, `suspended` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_empty | input | N | Per-process: all input queues empty |
| job_done | input | N | Per-process one-cycle job completion pulse |
| idle | input | N | Per-process idle flag |
| pwr_est | input | N*PW | Per-process power estimate, process i in bits [i*PW +: PW] |
| slow_tick | input | 1 | Slow preemption tick |
| preempt_mode | input | 1 | 0 cooperative, 1 preemptive |
| idle_gate_cfg | input | 1 | 1 makes inhibit follow idle |
| cap_en | input | 1 | Enables the power cap |
| cap_max | input | PW | Power cap limit |
| suspended | output | N | Per-process suspended state |
| clk_inhibit | output | N | Registered per-process clock-inhibit enable |
| cap_miss | output | 1 | No candidate met the cap at the last choice |

## Verification
The hardest case to reach is a choice in which inactivity rank overrides index order. Ranks only diverge after a chain of earlier activations. The stimulus first parks three processes and then hands over twice with tied ranks. This leaves a higher-index process ahead in rank, and the third handover must pick it. A cap miss is reached the same way: after a capped handover, the only stalled processes left all exceed the limit.

// File: rtl/fair_gate_sched.sv
module fair_gate_sched #(
  parameter int N  = 4,
  parameter int PW = 8,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    q_empty,
  input  logic [N-1:0]    job_done,
  input  logic [N-1:0]    idle,
  input  logic [N*PW-1:0] pwr_est,
  input  logic            slow_tick,
  input  logic            preempt_mode,
  input  logic            idle_gate_cfg,
  input  logic            cap_en,
  input  logic [PW-1:0]   cap_max,
  output logic [N-1:0]    suspended,
  output logic [N-1:0]    clk_inhibit,
  output logic            cap_miss
);
  localparam logic [RW-1:0] RANK_TOP = RW'(N - 1);

  logic [N-1:0]  susp_q, inh_q;
  logic          miss_q;
  logic [RW-1:0] rank_q [N];

  logic [N-1:0] running, stalled, cand, fits, capped, keep, park, win_oh, ctl, activ, susp_nx;
  logic         all_empty, any_stalled, coop_trig, switch_ev, wake_ev, choose, use_capped;
  logic [RW-1:0] sel_c, sel_a;
  logic          fnd_c, fnd_a;

  assign running     = ~susp_q;
  assign stalled     = susp_q & ~idle;
  assign all_empty   = &q_empty;
  assign any_stalled = |stalled;
  assign coop_trig   = |(running & (job_done | idle));
  assign switch_ev   = any_stalled && (preempt_mode ? slow_tick : coop_trig);
  assign wake_ev     = !switch_ev && (&susp_q) && !all_empty;
  assign choose      = switch_ev || wake_ev;
  assign cand        = any_stalled ? stalled : (susp_q & ~q_empty);

  for (genvar g = 0; g < N; g++) begin : g_fit
    assign fits[g] = !cap_en || (pwr_est[g*PW +: PW] <= cap_max);
  end
  assign capped     = cand & fits;
  assign use_capped = |capped;

  always_comb begin
    sel_c = '0; fnd_c = 1'b0;
    sel_a = '0; fnd_a = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (capped[i] && (!fnd_c || rank_q[i] > rank_q[sel_c])) begin
        sel_c = RW'(i); fnd_c = 1'b1;
      end
      if (cand[i] && (!fnd_a || rank_q[i] > rank_q[sel_a])) begin
        sel_a = RW'(i); fnd_a = 1'b1;
      end
    end
  end

  always_comb begin
    win_oh = '0;
    if (choose && (fnd_c || fnd_a))
      win_oh[use_capped ? sel_c : sel_a] = 1'b1;
  end

  assign keep    = running & ~(idle & q_empty);
  assign park    = running & idle & q_empty & {N{all_empty || (|keep)}};
  assign ctl     = choose ? (running | win_oh) : park;
  assign activ   = susp_q & ctl;
  assign susp_nx = susp_q ^ ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= '0;
      inh_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      susp_q <= susp_nx;
      inh_q  <= idle_gate_cfg ? idle : susp_nx;
      miss_q <= choose && cap_en && !use_capped;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rank_q[g] <= '0;
      else if (activ[g])                       rank_q[g] <= '0;
      else if ((|activ) && rank_q[g] != RANK_TOP) rank_q[g] <= rank_q[g] + 1'b1;
    end
  end

  assign suspended   = susp_q;
  assign clk_inhibit = inh_q;
  assign cap_miss    = miss_q;

  AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((&suspended) && !(&q_empty)) |=> !(&suspended)); // R5
  AST_ONE_RUNNER: assert property (@(posedge clk) disable iff (!rst_n)
    switch_ev |=> ($countones(~suspended) == 1)); // R2
  AST_INHIBIT_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clk_inhibit & ~suspended)) |-> $past(idle_gate_cfg)); // R8
  AST_MISS_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_miss |-> $past(cap_en)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!choose && !(|park)) |=> $stable(suspended)); // R9
endmodule

// File: tb/fair_gate_sched_tb_top.sv
`timescale 1ns/1ps
module fair_gate_sched_tb_top;
  localparam int N = 4, PW = 8;
  logic clk = 1'b0, rst_n;
  logic [N-1:0] q_empty, job_done, idle;
  logic [N*PW-1:0] pwr_est;
  logic slow_tick, preempt_mode, idle_gate_cfg, cap_en;
  logic [PW-1:0] cap_max;
  logic [N-1:0] suspended, clk_inhibit;
  logic cap_miss;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  fair_gate_sched #(.N(N), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .job_done(job_done), .idle(idle),
    .pwr_est(pwr_est), .slow_tick(slow_tick), .preempt_mode(preempt_mode),
    .idle_gate_cfg(idle_gate_cfg), .cap_en(cap_en), .cap_max(cap_max),
    .suspended(suspended), .clk_inhibit(clk_inhibit), .cap_miss(cap_miss));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    q_empty = '0; job_done = '0; idle = '0; pwr_est = '0; slow_tick = 0;
    preempt_mode = 0; idle_gate_cfg = 0; cap_en = 0; cap_max = '0;
    rst_n = 0; tick(); tick();
    rst_n = 1; #1;
  endtask

  task automatic park_three();
    q_empty = 4'b1110; idle = 4'b1110; job_done = '0;
    tick();
    chk("R6 park", suspended, 4'b1110);
    q_empty = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 suspended", suspended, '0);
    chk("R1 inhibit", clk_inhibit, '0);
    chk("R1 cap_miss", {3'b0, cap_miss}, '0);
  endtask

  task automatic t_coop_rank();
    do_reset(); park_three();
    chk("R8 inhibit follows suspended", clk_inhibit, 4'b1110);
    idle = 4'b0010; job_done = 4'b0001; tick();
    chk("R2 R4 tie to index 2", suspended, 4'b1011);
    idle = 4'b0010; job_done = 4'b0100; tick();
    chk("R4 tie to index 0", suspended, 4'b1110);
    idle = 4'b0010; job_done = 4'b0001; tick();
    chk("R4 rank beats index", suspended, 4'b0111);
    job_done = '0; idle = '0; tick();
    chk("R9 hold", suspended, 4'b0111);
  endtask

  task automatic t_preempt();
    do_reset(); park_three();
    preempt_mode = 1; idle = 4'b1100; job_done = 4'b0001; tick();
    chk("R3 done ignored", suspended, 4'b1110);
    job_done = '0; slow_tick = 1; tick();
    chk("R3 tick switches", suspended, 4'b1101);
    slow_tick = 0;
  endtask

  task automatic t_cap();
    do_reset(); park_three();
    cap_en = 1; cap_max = 8'd10;
    pwr_est = {8'd30, 8'd5, 8'd20, 8'd0};
    idle = 4'b1000; job_done = 4'b0001; tick();
    chk("R7 capped pick", suspended, 4'b1011);
    chk("R7 no miss", {3'b0, cap_miss}, 4'b0000);
    idle = 4'b0001; job_done = 4'b0100; tick();
    chk("R7 fallback pick", suspended, 4'b1101);
    chk("R7 miss flag", {3'b0, cap_miss}, 4'b0001);
  endtask

  task automatic t_wake();
    do_reset();
    q_empty = 4'b1111; idle = 4'b1111; tick();
    chk("R6 all park when all empty", suspended, 4'b1111);
    q_empty = 4'b0111; idle = 4'b0111; tick();
    chk("R5 wake", suspended, 4'b0111);
    idle_gate_cfg = 1; idle = 4'b0101; tick();
    chk("R8 idle gating", clk_inhibit, 4'b0101);
  endtask

  initial begin
    t_reset();
    t_coop_rank();
    t_preempt();
    t_cap();
    t_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule